// File: doc/BRIEF.md
# Matrix Key Event Generator with Ghost Rejection

This block sits behind a keyboard matrix scanner. Each scan produces one frame. A frame holds up to eight scancodes of pressed keys, a count, and a flag that says the scan found nothing pressed. The block compares each frame with the set of keys it reported last time. It then emits a serial burst of key events, one per handshake: first a release for every key that has gone away, then a press for every key in the new frame. A one-cycle done strobe closes every burst. Afterwards the block remembers the new frame as its reported set.

Two optional filters act on a frame before any event goes out.

- **Ghost filter.** A matrix can show a phantom key when three real keys form the corners of a rectangle. When the filter is on and the frame has three or more keys, the block looks for this pattern. If some pair of keys shares a row and some pair shares a column, the whole frame is discarded.
- **Function layer.** When the function map is on and the designated function key is in the frame, that key is not reported. Every other key moves into an upper code bank.

The state machine runs through five states:

- `ST_IDLE` waits for a frame. Transition *accept*: `frm_valid` while ready.
- `ST_ANALYZE` removes the function key, compacts the list and runs the ghost test. Transition *reject* goes to `ST_FINISH`. Transition *proceed* goes to `ST_RELEASE`.
- `ST_RELEASE` walks the stored set. It steps past keys that are still down, and *advances* on each accepted release event. Transition *releases done* goes to `ST_PRESS`.
- `ST_PRESS` walks the new list, one accepted press per step. Transition *presses done* goes to `ST_FINISH`.
- `ST_FINISH` pulses done and commits the new set unless the frame was rejected. Transition *return* goes to `ST_IDLE`.

Top module: `kev_event_gen`

## Requirements
- R1: A scancode is row*8+column. The column is the low 3 bits and the row is the 4 bits above them, and the ghost test compares rows and columns through these fields. With the filter on, the frame {3, 11, 13} is rejected.
- R2: A frame is taken when `frm_valid` is high while `frm_ready` is high, and `frm_ready` is high only in the idle state. Every taken frame ends with exactly one single-cycle `burst_done` pulse after its last event. After that pulse the block is ready again.
- R3: With the ghost filter on and at least three keys kept, a frame is rejected if any pair of keys shares a row and any pair shares a column. A rejected frame produces no events and leaves the stored set unchanged.
- R4: The ghost test does not act when the filter is off, or when the keys share only rows or only columns. Such frames are reported normally.
- R5: With the function map on and code `FN_CODE` (default 7) in the frame, that key produces no event. Every other key is reported with 128 added: bit 7 of `ev_code` is set and the low 7 bits keep the scancode.
- R6: With the function map off, code `FN_CODE` is an ordinary key, reported with bit 7 clear.
- R7: A release is emitted for each stored key whose 8-bit code is absent from the new list. Releases come in stored order, with `ev_pressed`=0, before any press.
- R8: After the releases, a press with `ev_pressed`=1 is emitted for every key of the new list in frame order. This includes keys that were already down.
- R9: After a frame that is not rejected, the stored set becomes the new list, including its bank bit and count.
- R10: With `frm_empty` set, the codes and count are ignored. A release is emitted for every stored key and the stored set becomes empty.
- R11: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_code` and `ev_pressed` hold steady.
- R12: After reset the block is idle and ready, shows no event and no done pulse, and its stored set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Block is idle and takes a frame |
| frm_codes | input | SLOTS*CODE_W (56) | Scancodes; slot k in bits [k*7 +: 7] |
| frm_count | input | CNT_W (4) | Number of valid slots, from 0 to 8 |
| frm_empty | input | 1 | Scanner found no key pressed |
| cfg_ghost_en | input | 1 | Enable the ghost filter |
| cfg_fn_en | input | 1 | Enable the function layer |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Event consumer accepts |
| ev_code | output | EV_W (8) | Event key code, with the bank in bit 7 |
| ev_pressed | output | 1 | 1 for a press, 0 for a release |
| burst_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench builds the block with its default parameters: eight slots, a 4-bit row field, a 3-bit column field and function code 7. These values make several boundary cases reachable with short frames:

- a full eight-key frame;
- the two-bank code space up to 255;
- ghost rectangles whose decode depends on the row/column split.

Events are also drained under an irregular ready pattern, so the hold behaviour of the handshake is exercised across long release and press runs.

// File: rtl/kev_pkg.sv
package kev_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ANALYZE,
        ST_RELEASE,
        ST_PRESS,
        ST_FINISH
    } kev_state_e;
endpackage

// File: rtl/kev_frame_prep.sv
module kev_frame_prep #(
    parameter int SLOTS   = 8,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 3,
    parameter int FN_CODE = 7,
    localparam int CODE_W = ROW_W + COL_W,
    localparam int EV_W   = CODE_W + 1,
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0][CODE_W-1:0] raw_codes,
    input  logic [CNT_W-1:0]             raw_cnt,
    input  logic                         raw_empty,
    input  logic                         ghost_en,
    input  logic                         fn_en,
    output logic [SLOTS-1:0][EV_W-1:0]   keep_codes,
    output logic [CNT_W-1:0]             keep_cnt,
    output logic                         reject
);
    localparam logic [CNT_W-1:0] GHOST_MIN = CNT_W'(3);

    logic fn_hit;
    logic row_hit;
    logic col_hit;

    // function key detection and compaction of the kept keys
    always_comb begin
        fn_hit     = 1'b0;
        keep_codes = '0;
        keep_cnt   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (fn_en && !raw_empty && CNT_W'(i) < raw_cnt &&
                raw_codes[i] == CODE_W'(FN_CODE))
                fn_hit = 1'b1;
        end
        if (!raw_empty) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (CNT_W'(i) < raw_cnt &&
                    !(fn_hit && raw_codes[i] == CODE_W'(FN_CODE))) begin
                    keep_codes[keep_cnt[IDX_W-1:0]] = {fn_hit, raw_codes[i]};
                    keep_cnt = keep_cnt + 1'b1;
                end
            end
        end
    end

    // rectangle test over every pair of kept keys
    always_comb begin
        row_hit = 1'b0;
        col_hit = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (i < j && CNT_W'(j) < keep_cnt) begin
                    if (keep_codes[i][COL_W-1:0] == keep_codes[j][COL_W-1:0])
                        col_hit = 1'b1;
                    if (keep_codes[i][CODE_W-1:COL_W] == keep_codes[j][CODE_W-1:COL_W])
                        row_hit = 1'b1;
                end
            end
        end
        reject = ghost_en && (keep_cnt >= GHOST_MIN) && row_hit && col_hit;
    end
endmodule

// File: rtl/kev_match.sv
module kev_match #(
    parameter int SLOTS  = 8,
    parameter int EV_W   = 8,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [EV_W-1:0]            probe,
    input  logic [SLOTS-1:0][EV_W-1:0] list,
    input  logic [CNT_W-1:0]           list_cnt,
    output logic                       hit
);
    logic [SLOTS-1:0] eq;

    for (genvar k = 0; k < SLOTS; k++) begin : g_cmp
        assign eq[k] = (CNT_W'(k) < list_cnt) && (list[k] == probe);
    end

    assign hit = |eq;
endmodule

// File: rtl/kev_event_gen.sv
module kev_event_gen
    import kev_pkg::*;
#(
    parameter int SLOTS   = 8,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 3,
    parameter int FN_CODE = 7,
    localparam int CODE_W = ROW_W + COL_W,
    localparam int EV_W   = CODE_W + 1,
    localparam int CNT_W  = $clog2(SLOTS + 1),
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_valid,
    output logic                    frm_ready,
    input  logic [SLOTS*CODE_W-1:0] frm_codes,
    input  logic [CNT_W-1:0]        frm_count,
    input  logic                    frm_empty,
    input  logic                    cfg_ghost_en,
    input  logic                    cfg_fn_en,
    output logic                    ev_valid,
    input  logic                    ev_ready,
    output logic [EV_W-1:0]         ev_code,
    output logic                    ev_pressed,
    output logic                    burst_done
);
    kev_state_e state_q, state_d;

    logic [SLOTS-1:0][CODE_W-1:0] raw_q;
    logic [CNT_W-1:0]             raw_cnt_q;
    logic                         raw_empty_q;
    logic                         ghost_q;
    logic                         fn_q;

    logic [SLOTS-1:0][EV_W-1:0]   new_q;
    logic [CNT_W-1:0]             new_cnt_q;
    logic [SLOTS-1:0][EV_W-1:0]   old_q;
    logic [CNT_W-1:0]             old_cnt_q;
    logic [CNT_W-1:0]             idx_q, idx_d;
    logic                         drop_q;

    logic [SLOTS-1:0][EV_W-1:0]   prep_codes;
    logic [CNT_W-1:0]             prep_cnt;
    logic                         prep_reject;
    logic                         rel_hit;
    logic                         old_left;
    logic                         new_left;
    logic [IDX_W-1:0]             idx_sel;

    assign idx_sel  = idx_q[IDX_W-1:0];
    assign old_left = idx_q < old_cnt_q;
    assign new_left = idx_q < new_cnt_q;

    kev_frame_prep #(
        .SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W), .FN_CODE(FN_CODE)
    ) u_prep (
        .raw_codes (raw_q),
        .raw_cnt   (raw_cnt_q),
        .raw_empty (raw_empty_q),
        .ghost_en  (ghost_q),
        .fn_en     (fn_q),
        .keep_codes(prep_codes),
        .keep_cnt  (prep_cnt),
        .reject    (prep_reject)
    );

    kev_match #(.SLOTS(SLOTS), .EV_W(EV_W)) u_match (
        .probe   (old_q[idx_sel]),
        .list    (new_q),
        .list_cnt(new_cnt_q),
        .hit     (rel_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and walk index
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frm_valid) state_d = ST_ANALYZE;
            end
            ST_ANALYZE: begin
                idx_d   = '0;
                state_d = prep_reject ? ST_FINISH : ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!old_left) begin
                    idx_d   = '0;
                    state_d = ST_PRESS;
                end else if (rel_hit || ev_ready) begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_PRESS: begin
                if (!new_left)     state_d = ST_FINISH;
                else if (ev_ready) idx_d = idx_q + 1'b1;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs from state
    always_comb begin
        frm_ready  = 1'b0;
        ev_valid   = 1'b0;
        ev_code    = '0;
        ev_pressed = 1'b0;
        burst_done = 1'b0;
        unique case (state_q)
            ST_IDLE:    frm_ready = 1'b1;
            ST_ANALYZE: ;
            ST_RELEASE: begin
                if (old_left && !rel_hit) begin
                    ev_valid = 1'b1;
                    ev_code  = old_q[idx_sel];
                end
            end
            ST_PRESS: begin
                if (new_left) begin
                    ev_valid   = 1'b1;
                    ev_code    = new_q[idx_sel];
                    ev_pressed = 1'b1;
                end
            end
            ST_FINISH:  burst_done = 1'b1;
            default:    ;
        endcase
    end

    // frame capture and stored set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q       <= '0;
            raw_cnt_q   <= '0;
            raw_empty_q <= 1'b0;
            ghost_q     <= 1'b0;
            fn_q        <= 1'b0;
            new_q       <= '0;
            new_cnt_q   <= '0;
            old_q       <= '0;
            old_cnt_q   <= '0;
            idx_q       <= '0;
            drop_q      <= 1'b0;
        end else begin
            idx_q <= idx_d;
            if (state_q == ST_IDLE && frm_valid) begin
                raw_q       <= frm_codes;
                raw_cnt_q   <= frm_count;
                raw_empty_q <= frm_empty;
                ghost_q     <= cfg_ghost_en;
                fn_q        <= cfg_fn_en;
            end
            if (state_q == ST_ANALYZE) begin
                new_q     <= prep_codes;
                new_cnt_q <= prep_cnt;
                drop_q    <= prep_reject;
            end
            if (state_q == ST_FINISH && !drop_q) begin
                old_q     <= new_q;
                old_cnt_q <= new_cnt_q;
            end
        end
    end
endmodule

// File: rtl/kev_checker.sv
module kev_checker #(
    parameter int EV_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frm_valid,
    input logic            frm_ready,
    input logic            ev_valid,
    input logic            ev_ready,
    input logic [EV_W-1:0] ev_code,
    input logic            ev_pressed,
    input logic            burst_done
);
    // R11: a stalled event holds
    a_r11_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_pressed));

    // R2: done lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    // R2: done returns the block to ready
    a_r2_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> frm_ready);

    // R2: an accepted frame makes the block busy
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && frm_ready |=> !frm_ready);

    // R2: no event or done while ready
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ready |-> !ev_valid && !burst_done);

    // R7: events never overlap the done strobe
    a_r7_no_event_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_valid && burst_done));
endmodule

bind kev_event_gen kev_checker #(.EV_W(EV_W)) u_kev_checker (.*);

// File: tb/test_kev_event_gen.sv
module test_kev_event_gen;
    localparam int SLOTS = 8;
    localparam int CW    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_valid = 1'b0;
    logic frm_ready;
    logic [SLOTS*CW-1:0] frm_codes = '0;
    logic [3:0] frm_count = '0;
    logic frm_empty = 1'b0;
    logic cfg_ghost_en = 1'b0;
    logic cfg_fn_en = 1'b0;
    logic ev_valid;
    logic ev_ready = 1'b1;
    logic [7:0] ev_code;
    logic ev_pressed;
    logic burst_done;

    always #4 clk = ~clk;

    kev_event_gen i_kev_event_gen (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_codes(frm_codes), .frm_count(frm_count), .frm_empty(frm_empty),
        .cfg_ghost_en(cfg_ghost_en), .cfg_fn_en(cfg_fn_en),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code),
        .ev_pressed(ev_pressed), .burst_done(burst_done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // event log filled by the monitor
    int got_ev [64];
    int got_n = 0;
    int done_cnt = 0;
    bit stall = 0;
    int stall_cyc = 0;

    // reference state and stimulus
    int old_m [SLOTS];
    int old_n = 0;
    int f_codes [SLOTS];
    int f_cnt = 0;
    bit f_empty = 0;
    int exp_ev [64];
    int exp_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (stall) ev_ready = (stall_cyc % 3 == 2);
            else       ev_ready = 1'b1;
            stall_cyc++;
            if (ev_valid && ev_ready && got_n < 64) begin
                got_ev[got_n] = {23'd0, ev_pressed, ev_code};
                got_n++;
            end
            if (burst_done) done_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_frame();
        int keep [SLOTS];
        int kn = 0;
        bit fnh = 0;
        bit rh = 0;
        bit chh = 0;
        bit found;
        exp_n = 0;
        if (!f_empty) begin
            for (int i = 0; i < f_cnt; i++)
                if (cfg_fn_en && f_codes[i] == 7) fnh = 1;
            for (int i = 0; i < f_cnt; i++)
                if (!(fnh && f_codes[i] == 7)) begin
                    keep[kn] = f_codes[i] + (fnh ? 128 : 0);
                    kn++;
                end
        end
        for (int i = 0; i < kn; i++)
            for (int j = i + 1; j < kn; j++) begin
                if ((keep[i] % 8) == (keep[j] % 8)) chh = 1;
                if (((keep[i] / 8) % 16) == ((keep[j] / 8) % 16)) rh = 1;
            end
        if (cfg_ghost_en && kn >= 3 && rh && chh) return;
        for (int i = 0; i < old_n; i++) begin
            found = 0;
            for (int j = 0; j < kn; j++) if (keep[j] == old_m[i]) found = 1;
            if (!found) begin exp_ev[exp_n] = old_m[i]; exp_n++; end
        end
        for (int j = 0; j < kn; j++) begin
            exp_ev[exp_n] = 256 + keep[j];
            exp_n++;
        end
        for (int j = 0; j < kn; j++) old_m[j] = keep[j];
        old_n = kn;
    endtask

    task automatic run_frame(input string req);
        int wait_cyc = 0;
        model_frame();
        @(negedge clk);
        while (!frm_ready) @(negedge clk);
        got_n = 0;
        done_cnt = 0;
        for (int i = 0; i < SLOTS; i++)
            frm_codes[i*CW +: CW] = (i < f_cnt) ? f_codes[i][CW-1:0] : 7'd0;
        frm_count = f_cnt[3:0];
        frm_empty = f_empty;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        while (done_cnt == 0 && wait_cyc < 500) begin
            @(negedge clk);
            wait_cyc++;
        end
        @(negedge clk);
        chk(done_cnt == 1, "R2", "done pulses", done_cnt, 1);
        chk(frm_ready == 1'b1, "R2", "ready after burst", int'(frm_ready), 1);
        chk(got_n == exp_n, req, "event count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got_ev[i] == exp_ev[i], req, "event {pressed,code}", got_ev[i], exp_ev[i]);
    endtask

    task automatic set_frame(input int n, input int c0, input int c1, input int c2,
                             input int c3, input int c4, input int c5,
                             input int c6, input int c7);
        f_cnt = n;
        f_empty = 0;
        f_codes[0] = c0; f_codes[1] = c1; f_codes[2] = c2; f_codes[3] = c3;
        f_codes[4] = c4; f_codes[5] = c5; f_codes[6] = c6; f_codes[7] = c7;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(frm_ready == 1'b1, "R12", "ready after reset", int'(frm_ready), 1);
        chk(ev_valid == 1'b0, "R12", "no event after reset", int'(ev_valid), 0);
        chk(burst_done == 1'b0, "R12", "no done after reset", int'(burst_done), 0);
        cfg_ghost_en = 1; cfg_fn_en = 1;
        set_frame(1, 20, 0, 0, 0, 0, 0, 0, 0);
        run_frame("R12");
    endtask

    task automatic t_press_release();
        set_frame(2, 20, 35, 0, 0, 0, 0, 0, 0);
        run_frame("R8");
        set_frame(1, 35, 0, 0, 0, 0, 0, 0, 0);
        run_frame("R7");
    endtask

    task automatic t_ghost();
        set_frame(3, 8, 9, 16, 0, 0, 0, 0, 0);
        run_frame("R3");
        chk(got_n == 0, "R3", "ghost frame silent", got_n, 0);
        set_frame(1, 35, 0, 0, 0, 0, 0, 0, 0);
        run_frame("R9");
        set_frame(3, 3, 11, 13, 0, 0, 0, 0, 0);
        run_frame("R1");
        chk(got_n == 0, "R1", "field decoded ghost", got_n, 0);
        cfg_ghost_en = 0;
        set_frame(3, 8, 9, 16, 0, 0, 0, 0, 0);
        run_frame("R4");
        cfg_ghost_en = 1;
        set_frame(3, 0, 9, 18, 0, 0, 0, 0, 0);
        run_frame("R4");
    endtask

    task automatic t_fn();
        cfg_fn_en = 1;
        set_frame(3, 7, 9, 40, 0, 0, 0, 0, 0);
        run_frame("R5");
        chk(got_n >= 2 && got_ev[got_n-2] == 256 + 137, "R5", "banked code",
            got_ev[got_n-2], 256 + 137);
        cfg_fn_en = 0;
        set_frame(2, 7, 9, 0, 0, 0, 0, 0, 0);
        run_frame("R6");
    endtask

    task automatic t_stall_full();
        cfg_ghost_en = 0;
        stall = 1;
        set_frame(8, 1, 2, 60, 100, 127, 64, 5, 90);
        run_frame("R11");
        stall = 0;
    endtask

    task automatic t_empty();
        f_empty = 1;
        f_cnt = 3;
        run_frame("R10");
        chk(got_n == 8, "R10", "release all stored", got_n, 8);
        f_empty = 1;
        f_cnt = 2;
        run_frame("R10");
        chk(got_n == 0, "R10", "nothing left to release", got_n, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_press_release();
        t_ghost();
        t_fn();
        t_stall_full();
        t_empty();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule